// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is the control core of a single DMA channel. Software programs it through a small word-indexed register port. It writes the address of a descriptor and sets the run bit. The sequencer then reads the 8-word descriptor from memory one word at a time, keeps the first six words in read-only channel registers and hands them to an external transfer engine through a start pulse. When the engine reports done, the sequencer copies the descriptor's next pointer into the descriptor-address register and fetches again. A null next pointer ends the chain: the run bit drops and the channel goes idle.

The state machine has five states. IDLE waits for the run bit and a non-zero descriptor address (transition IDLE to FETCH). FETCH issues eight word reads; after the last word it goes to RUN and pulses the engine start. If an abort arrived during the fetch, it goes to COMPLETE instead. RUN waits for the engine's done or a software abort (RUN to COMPLETE). COMPLETE raises the done and interrupt flags for a descriptor that finished normally, and loads the next pointer into the descriptor address. It then goes to FETCH when that pointer is non-zero, or to STOP when it is zero. STOP clears the run bit (STOP to IDLE). A soft reset sends every state to IDLE.

Clearing the run bit pauses the channel in FETCH or RUN, and setting it again resumes. While paused, the next pointer may be rewritten to edit the chain.

Top module: `dma_chain_seq`

## Requirements
- R1: A descriptor fetch begins only when the run bit (CTRL bit 0) is 1 and the descriptor-address register is non-zero. With a zero address the channel stays in IDLE and issues no memory request.
- R2: A descriptor occupies 32 bytes. Bits 4:0 of the descriptor-address register and of the next-pointer register are forced to zero on every load or write, and they read back as zero.
- R3: A fetch reads the eight words at descriptor address + 4*k for k = 0..7, in that order, with one request outstanding at a time. Words 0..5 land in INFO, SRC, DST, LEN, STRIDE and NEXT (register indexes 2..7), and words 6 and 7 are discarded. The SRC, DST, LEN, STRIDE and INFO values also drive the engine outputs. Without an abort, xfer_start pulses for one cycle after the eighth word.
- R4: When the engine reports done in RUN, the NEXT value is copied into the descriptor-address register. If it is non-zero, a new fetch starts from that address.
- R5: When the NEXT value is zero at completion, the descriptor-address register becomes zero, the run bit is cleared and the channel returns to IDLE.
- R6: The DONE flag (CTRL bit 1) is set by each normally completed descriptor and cleared by writing 1 to that bit. Writing 0 to the bit leaves it unchanged.
- R7: The IRQ flag (CTRL bit 2, also the irq output) is set at normal completion only when INFO bit 0 of that descriptor is 1. It stays set through later descriptors until software writes 1 to the bit.
- R8: Writing 1 to the abort bit (CTRL bit 6) in RUN pulses xfer_abort. The current descriptor is abandoned without setting DONE or IRQ, and the chain continues with its NEXT pointer.
- R9: An abort written during FETCH is held until all eight words have been read. No xfer_start is issued, and the channel then advances as in R8.
- R10: Clearing the run bit in FETCH or RUN sets the PAUSED status (CTRL bit 3), raises xfer_pause in RUN and withholds new memory requests. Setting the bit again resumes from the same point.
- R11: Writes to INFO, SRC, DST, LEN, STRIDE and to the debug register (index 8) have no effect. NEXT accepts writes only while PAUSED is 1. The descriptor-address register accepts writes only in IDLE.
- R12: Writing 1 to the reset bit (CTRL bit 7) returns every register and the state to reset values on the next cycle. If the channel was in RUN, it also pulses xfer_abort.
- R13: After reset every readable register is zero. The abort and reset bits always read 0. The debug register reads the state code in bits 2:0: IDLE=0, FETCH=1, RUN=2, COMPLETE=3, STOP=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | RIX_W | Register word index for reads and writes |
| reg_wdata | input | WORD_W | Register write data |
| reg_rdata | output | WORD_W | Read data for reg_addr (combinational) |
| mem_req | output | 1 | One-cycle descriptor word read request |
| mem_addr | output | WORD_W | Byte address of the requested word |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | WORD_W | Read data |
| xfer_start | output | 1 | Start pulse to the transfer engine |
| xfer_abort | output | 1 | Abandon pulse to the transfer engine |
| xfer_pause | output | 1 | Engine hold while the channel is paused in RUN |
| xfer_done | input | 1 | Engine reports the transfer length reached zero |
| xfer_info | output | WORD_W | Loaded transfer-information word |
| xfer_src | output | WORD_W | Loaded source address |
| xfer_dst | output | WORD_W | Loaded destination address |
| xfer_len | output | WORD_W | Loaded transfer length |
| xfer_stride | output | WORD_W | Loaded stride word |
| irq | output | 1 | IRQ flag |

## Verification
Some rules are checked on every cycle. xfer_start may only follow a returned memory word, and a normal completion must set DONE. IRQ must hold until it is cleared, STOP must leave an idle channel with a zero address, and a soft reset must clear everything. A zero descriptor address must never lead to a fetch. Other behaviour shows only in the bench's scenarios. That covers the descriptor word order and the walk along chains of every length and interrupt pattern in a small sweep. It also covers pause and resume with a rewritten next pointer, deferred aborts during a fetch, and the register write protection.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FETCH    = 3'd1,
        ST_RUN      = 3'd2,
        ST_COMPLETE = 3'd3,
        ST_STOP     = 3'd4
    } chan_state_e;

    // register word indexes
    localparam int unsigned RIX_CTRL   = 0;
    localparam int unsigned RIX_DADDR  = 1;
    localparam int unsigned RIX_INFO   = 2;
    localparam int unsigned RIX_SRC    = 3;
    localparam int unsigned RIX_DST    = 4;
    localparam int unsigned RIX_LEN    = 5;
    localparam int unsigned RIX_STRIDE = 6;
    localparam int unsigned RIX_NEXT   = 7;
    localparam int unsigned RIX_DBG    = 8;

    // control word bit positions
    localparam int unsigned CB_RUN    = 0;
    localparam int unsigned CB_DONE   = 1;
    localparam int unsigned CB_IRQ    = 2;
    localparam int unsigned CB_PAUSED = 3;
    localparam int unsigned CB_SKIP   = 6;
    localparam int unsigned CB_SRST   = 7;

    // descriptor word slots kept in channel registers
    localparam int unsigned DW_INFO   = 0;
    localparam int unsigned DW_SRC    = 1;
    localparam int unsigned DW_DST    = 2;
    localparam int unsigned DW_LEN    = 3;
    localparam int unsigned DW_STRIDE = 4;
    localparam int unsigned DW_NEXT   = 5;
    localparam int unsigned KEPT_WORDS = 6;

    localparam int unsigned INFO_IRQ_EN = 0;

endpackage

// File: rtl/dma_desc_loader.sv
module dma_desc_loader
    import dma_chain_pkg::*;
#(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned DESC_WORDS = 8,
    parameter int unsigned ALIGN_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              fetch_en,
    input  logic              go,
    input  logic [WORD_W-1:0] base_addr,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              last_beat,
    input  logic              next_we,
    input  logic [WORD_W-1:0] next_wdata,
    output logic [WORD_W-1:0] word_info,
    output logic [WORD_W-1:0] word_src,
    output logic [WORD_W-1:0] word_dst,
    output logic [WORD_W-1:0] word_len,
    output logic [WORD_W-1:0] word_stride,
    output logic [WORD_W-1:0] word_next
);

    localparam int unsigned BEAT_W = $clog2(DESC_WORDS);
    localparam logic [WORD_W-1:0] KEEP_MASK = {{(WORD_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
    localparam logic [BEAT_W-1:0] LAST_IX = BEAT_W'(DESC_WORDS - 1);

    logic [BEAT_W-1:0] beat_q;
    logic              wait_q;
    logic              beat_ret;
    logic [WORD_W-1:0] kept_q [KEPT_WORDS];

    assign mem_req   = fetch_en && go && !wait_q;
    assign mem_addr  = base_addr + (WORD_W'(beat_q) << 2);
    assign beat_ret  = fetch_en && wait_q && mem_valid;
    assign last_beat = beat_ret && (beat_q == LAST_IX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            wait_q <= 1'b0;
        end else if (soft_rst || !fetch_en) begin
            beat_q <= '0;
            wait_q <= 1'b0;
        end else if (beat_ret) begin
            wait_q <= 1'b0;
            beat_q <= (beat_q == LAST_IX) ? '0 : beat_q + 1'b1;
        end else if (mem_req) begin
            wait_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < KEPT_WORDS; g++) begin : g_word
        if (g == DW_NEXT) begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    kept_q[g] <= '0;
                end else if (soft_rst) begin
                    kept_q[g] <= '0;
                end else if (beat_ret && beat_q == BEAT_W'(g)) begin
                    kept_q[g] <= mem_rdata & KEEP_MASK;
                end else if (next_we) begin
                    kept_q[g] <= next_wdata & KEEP_MASK;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    kept_q[g] <= '0;
                end else if (soft_rst) begin
                    kept_q[g] <= '0;
                end else if (beat_ret && beat_q == BEAT_W'(g)) begin
                    kept_q[g] <= mem_rdata;
                end
            end
        end
    end

    assign word_info   = kept_q[DW_INFO];
    assign word_src    = kept_q[DW_SRC];
    assign word_dst    = kept_q[DW_DST];
    assign word_len    = kept_q[DW_LEN];
    assign word_stride = kept_q[DW_STRIDE];
    assign word_next   = kept_q[DW_NEXT];

endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
    import dma_chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        go,
    input  logic        base_nz,
    input  logic        last_beat,
    input  logic        next_nz,
    input  logic        xfer_done,
    input  logic        abort_req,
    output chan_state_e state,
    output logic        fetch_en,
    output logic        paused,
    output logic        xfer_pause,
    output logic        xfer_start,
    output logic        xfer_abort,
    output logic        ev_complete,
    output logic        ev_advance,
    output logic        ev_stop
);

    chan_state_e state_q, state_d;
    logic        abort_pend_q;
    logic        skip_q;
    logic        start_q;
    logic        kill_q;
    logic        abort_any;

    assign abort_any = abort_pend_q || abort_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (go && base_nz) state_d = ST_FETCH;
            ST_FETCH:    if (last_beat) state_d = abort_any ? ST_COMPLETE : ST_RUN;
            ST_RUN:      if (xfer_done || abort_req) state_d = ST_COMPLETE;
            ST_COMPLETE: state_d = next_nz ? ST_FETCH : ST_STOP;
            ST_STOP:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (soft_rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_pend_q <= 1'b0;
            skip_q       <= 1'b0;
            start_q      <= 1'b0;
            kill_q       <= 1'b0;
        end else if (soft_rst) begin
            abort_pend_q <= 1'b0;
            skip_q       <= 1'b0;
            start_q      <= 1'b0;
            kill_q       <= (state_q == ST_RUN);
        end else begin
            start_q <= (state_q == ST_FETCH) && last_beat && !abort_any;
            kill_q  <= (state_q == ST_RUN) && abort_req && !xfer_done;
            if (state_q == ST_FETCH && !last_beat) begin
                abort_pend_q <= abort_any;
            end else begin
                abort_pend_q <= 1'b0;
            end
            if ((state_q == ST_FETCH && last_beat && abort_any) ||
                (state_q == ST_RUN && abort_req && !xfer_done)) begin
                skip_q <= 1'b1;
            end else if (state_q == ST_COMPLETE) begin
                skip_q <= 1'b0;
            end
        end
    end

    always_comb begin
        state       = state_q;
        fetch_en    = (state_q == ST_FETCH);
        paused      = (state_q == ST_FETCH || state_q == ST_RUN) && !go;
        xfer_pause  = (state_q == ST_RUN) && !go;
        xfer_start  = start_q;
        xfer_abort  = kill_q;
        ev_advance  = (state_q == ST_COMPLETE);
        ev_complete = (state_q == ST_COMPLETE) && !skip_q;
        ev_stop     = (state_q == ST_STOP);
    end

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dma_chain_pkg::*;
#(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned DESC_WORDS = 8,
    parameter int unsigned RIX_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [RIX_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_start,
    output logic              xfer_abort,
    output logic              xfer_pause,
    input  logic              xfer_done,
    output logic [WORD_W-1:0] xfer_info,
    output logic [WORD_W-1:0] xfer_src,
    output logic [WORD_W-1:0] xfer_dst,
    output logic [WORD_W-1:0] xfer_len,
    output logic [WORD_W-1:0] xfer_stride,
    output logic              irq
);

    localparam int unsigned ALIGN_BITS = $clog2(DESC_WORDS * (WORD_W / 8));
    localparam logic [WORD_W-1:0] KEEP_MASK = {{(WORD_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

    logic              active_q, done_q, irq_q;
    logic [WORD_W-1:0] daddr_q;
    logic              ctrl_we, daddr_we, next_we;
    logic              soft_rst, abort_req, clr_done, clr_irq;
    logic              fetch_en, paused, last_beat;
    logic              ev_complete, ev_advance, ev_stop;
    logic [WORD_W-1:0] word_next;
    chan_state_e       state;

    assign ctrl_we   = reg_wr_en && (reg_addr == RIX_W'(RIX_CTRL));
    assign daddr_we  = reg_wr_en && (reg_addr == RIX_W'(RIX_DADDR));
    assign soft_rst  = ctrl_we && reg_wdata[CB_SRST];
    assign abort_req = ctrl_we && reg_wdata[CB_SKIP] && !reg_wdata[CB_SRST];
    assign clr_done  = ctrl_we && reg_wdata[CB_DONE];
    assign clr_irq   = ctrl_we && reg_wdata[CB_IRQ];
    assign next_we   = reg_wr_en && (reg_addr == RIX_W'(RIX_NEXT)) && paused;

    dma_chain_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .go          (active_q),
        .base_nz     (|daddr_q),
        .last_beat   (last_beat),
        .next_nz     (|word_next),
        .xfer_done   (xfer_done),
        .abort_req   (abort_req),
        .state       (state),
        .fetch_en    (fetch_en),
        .paused      (paused),
        .xfer_pause  (xfer_pause),
        .xfer_start  (xfer_start),
        .xfer_abort  (xfer_abort),
        .ev_complete (ev_complete),
        .ev_advance  (ev_advance),
        .ev_stop     (ev_stop)
    );

    dma_desc_loader #(
        .WORD_W     (WORD_W),
        .DESC_WORDS (DESC_WORDS),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .fetch_en    (fetch_en),
        .go          (active_q),
        .base_addr   (daddr_q),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_valid   (mem_valid),
        .mem_rdata   (mem_rdata),
        .last_beat   (last_beat),
        .next_we     (next_we),
        .next_wdata  (reg_wdata),
        .word_info   (xfer_info),
        .word_src    (xfer_src),
        .word_dst    (xfer_dst),
        .word_len    (xfer_len),
        .word_stride (xfer_stride),
        .word_next   (word_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            irq_q    <= 1'b0;
            daddr_q  <= '0;
        end else if (soft_rst) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            irq_q    <= 1'b0;
            daddr_q  <= '0;
        end else begin
            if (ev_stop) begin
                active_q <= 1'b0;
            end else if (ctrl_we) begin
                active_q <= reg_wdata[CB_RUN];
            end
            if (ev_complete) begin
                done_q <= 1'b1;
            end else if (clr_done) begin
                done_q <= 1'b0;
            end
            if (ev_complete && xfer_info[INFO_IRQ_EN]) begin
                irq_q <= 1'b1;
            end else if (clr_irq) begin
                irq_q <= 1'b0;
            end
            if (ev_advance) begin
                daddr_q <= word_next;
            end else if (daddr_we && state == ST_IDLE) begin
                daddr_q <= reg_wdata & KEEP_MASK;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RIX_W'(RIX_CTRL): begin
                reg_rdata[CB_RUN]    = active_q;
                reg_rdata[CB_DONE]   = done_q;
                reg_rdata[CB_IRQ]    = irq_q;
                reg_rdata[CB_PAUSED] = paused;
            end
            RIX_W'(RIX_DADDR):  reg_rdata = daddr_q;
            RIX_W'(RIX_INFO):   reg_rdata = xfer_info;
            RIX_W'(RIX_SRC):    reg_rdata = xfer_src;
            RIX_W'(RIX_DST):    reg_rdata = xfer_dst;
            RIX_W'(RIX_LEN):    reg_rdata = xfer_len;
            RIX_W'(RIX_STRIDE): reg_rdata = xfer_stride;
            RIX_W'(RIX_NEXT):   reg_rdata = word_next;
            RIX_W'(RIX_DBG):    reg_rdata[2:0] = state;
            default:            reg_rdata = '0;
        endcase
    end

    assign irq = irq_q;

endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk
    import dma_chain_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input chan_state_e       state,
    input logic              active,
    input logic              done,
    input logic              irq,
    input logic [WORD_W-1:0] daddr,
    input logic              xfer_start,
    input logic              mem_valid,
    input logic              clr_irq,
    input logic              ev_complete
);

    // R1
    no_null_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && daddr == '0 && !soft_rst) |=> (state != ST_FETCH));

    // R3
    start_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> $past(mem_valid));

    // R5
    stop_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !soft_rst) |=> (!active && daddr == '0 && state == ST_IDLE));

    // R6
    done_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_complete && !soft_rst) |=> done);

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_irq && !soft_rst) |=> irq);

    // R12
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state == ST_IDLE && !active && !done && !irq && daddr == '0));

endmodule

bind dma_chain_seq dma_chain_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .state       (state),
    .active      (active_q),
    .done        (done_q),
    .irq         (irq_q),
    .daddr       (daddr_q),
    .xfer_start  (xfer_start),
    .mem_valid   (mem_valid),
    .clr_irq     (clr_irq),
    .ev_complete (ev_complete)
);

// File: tb/dma_chain_seq_bench.sv
module dma_chain_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid;
    logic [31:0] mem_rdata;
    logic        xfer_start, xfer_abort, xfer_pause, xfer_done;
    logic [31:0] xfer_info, xfer_src, xfer_dst, xfer_len, xfer_stride;
    logic        irq;

    always #10 clk = ~clk;

    dma_chain_seq u_dma_chain_seq (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .xfer_start(xfer_start), .xfer_abort(xfer_abort), .xfer_pause(xfer_pause), .xfer_done(xfer_done),
        .xfer_info(xfer_info), .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_len(xfer_len),
        .xfer_stride(xfer_stride), .irq(irq)
    );

    // memory model: one-cycle read latency
    logic [31:0] mem [0:255];
    always @(posedge clk) begin
        mem_valid <= mem_req;
        mem_rdata <= mem[mem_addr[9:2]];
    end

    // transfer engine model: counts down LEN cycles unless held
    logic [31:0] ecnt;
    always @(posedge clk) begin
        if (!rst_n) ecnt <= '0;
        else if (xfer_abort) ecnt <= '0;
        else if (xfer_start) ecnt <= xfer_len;
        else if (ecnt != 0 && !xfer_pause) ecnt <= ecnt - 1;
    end
    assign xfer_done = (ecnt == 1) && !xfer_pause;

    int n_start = 0, n_abort = 0, n_req = 0;
    int a_checks = 0, a_fails = 0;
    logic [2:0] exp_beat = '0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (xfer_start) n_start++;
            if (xfer_abort) n_abort++;
            if (mem_req) begin
                n_req++;
                a_checks++;
                // R3: word k of a fetch sits at base + 4*k
                if (mem_addr[4:2] != exp_beat || mem_addr[1:0] != 2'b00) begin
                    a_fails++;
                    $display("FAIL R3: fetch address %h, expected word index %0d", mem_addr, exp_beat);
                end
                exp_beat <= exp_beat + 3'd1;
            end
        end
    end

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_state(input logic [31:0] code);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(4'd8, v);
            if (v == code) return;
        end
    endtask

    function automatic logic [31:0] src_of(int s);  return 32'h1000_0000 + s; endfunction
    function automatic logic [31:0] dst_of(int s);  return 32'h2000_0000 + s; endfunction
    function automatic logic [31:0] strd_of(int s); return 32'h0030_0000 + s; endfunction

    task automatic put_desc(input int s, input bit inten, input int len, input logic [31:0] nxt);
        mem[s*8 + 0] = {16'h5A00, 15'd0, inten};
        mem[s*8 + 1] = src_of(s);
        mem[s*8 + 2] = dst_of(s);
        mem[s*8 + 3] = len;
        mem[s*8 + 4] = strd_of(s);
        mem[s*8 + 5] = nxt;
        mem[s*8 + 6] = 32'hDEAD_0000 + s;
        mem[s*8 + 7] = 32'hBEEF_0000 + s;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks + a_checks, fails + a_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        int s0, r0, k0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13: reset values
        rd(4'd0, v); chk("R13 ctrl reset", v, 0);
        rd(4'd1, v); chk("R13 daddr reset", v, 0);
        rd(4'd2, v); chk("R13 info reset", v, 0);
        rd(4'd8, v); chk("R13 state reset", v, 0);
        chk("R13 irq reset", {31'd0, irq}, 0);

        // R1: run bit with zero address must not fetch
        r0 = n_req;
        wr(4'd0, 32'h1);
        repeat (10) @(negedge clk);
        rd(4'd8, v); chk("R1 stays idle", v, 0);
        chk("R1 no request", n_req - r0, 0);
        wr(4'd0, 32'h0);

        // R2: alignment
        wr(4'd1, 32'h0000_013F);
        rd(4'd1, v); chk("R2 daddr low bits", v, 32'h0000_0120);

        // sweep chain lengths and interrupt-enable patterns
        for (int n = 1; n <= 3; n++) begin
            for (int m = 0; m < (1 << n); m++) begin
                wr(4'd0, 32'h6);
                for (int s = 1; s <= n; s++)
                    put_desc(s, m[s-1], 2 + s, (s < n) ? (s + 1) * 32 : 0);
                wr(4'd1, 32'h20);
                s0 = n_start;
                wr(4'd0, 32'h1);
                if (n == 1 && m == 0) begin
                    rd(4'd8, v); chk("R13 fetch code", v, 1);
                end
                wait_state(0);
                // R5, R6, R7
                rd(4'd0, v); chk("R6 R7 flags after chain", v, (m != 0) ? 32'h6 : 32'h2);
                chk("R7 irq pin", {31'd0, irq}, (m != 0) ? 1 : 0);
                rd(4'd1, v); chk("R5 daddr null", v, 0);
                chk("R4 one start per descriptor", n_start - s0, n);
                rd(4'd3, v); chk("R4 last descriptor loaded", v, src_of(n));
                if (n == 1 && m == 1) begin
                    // R3: word order into the channel registers
                    rd(4'd2, v); chk("R3 info word", v, mem[8]);
                    rd(4'd4, v); chk("R3 dst word", v, dst_of(1));
                    rd(4'd5, v); chk("R3 len word", v, 3);
                    rd(4'd6, v); chk("R3 stride word", v, strd_of(1));
                    rd(4'd7, v); chk("R3 next word", v, 0);
                    chk("R3 src output", xfer_src, src_of(1));
                end
            end
        end

        // R6: writing 0 leaves DONE, writing 1 clears
        wr(4'd0, 32'h0);
        rd(4'd0, v); chk("R6 write zero keeps", v & 32'h6, 32'h6);
        wr(4'd0, 32'h2);
        rd(4'd0, v); chk("R6 w1c done", v & 32'h2, 0);
        wr(4'd0, 32'h4);
        rd(4'd0, v); chk("R7 w1c irq", v & 32'h4, 0);

        // R10 / R11: pause, protected writes, next rewrite
        put_desc(1, 0, 30, 0);
        put_desc(2, 1, 2, 0);
        wr(4'd1, 32'h20);
        s0 = n_start;
        wr(4'd0, 32'h1);
        wait_state(2);
        wr(4'd7, 32'h60);
        rd(4'd7, v); chk("R11 next locked while running", v, 0);
        wr(4'd1, 32'h80);
        rd(4'd1, v); chk("R11 daddr locked outside idle", v, 32'h20);
        wr(4'd0, 32'h0);
        rd(4'd0, v); chk("R10 paused bit", v, 32'h8);
        chk("R10 engine hold", {31'd0, xfer_pause}, 1);
        repeat (60) @(negedge clk);
        rd(4'd8, v); chk("R10 held in run", v, 2);
        wr(4'd3, 32'hFFFF_FFFF);
        rd(4'd3, v); chk("R11 src read-only", v, src_of(1));
        wr(4'd8, 32'h7);
        rd(4'd8, v); chk("R11 debug read-only", v, 2);
        wr(4'd7, 32'h0000_0047);
        rd(4'd7, v); chk("R11 next rewrite while paused", v, 32'h40);
        wr(4'd0, 32'h1);
        wait_state(0);
        chk("R10 resume follows new next", n_start - s0, 2);
        rd(4'd0, v); chk("R10 resume completes", v, 32'h6);
        wr(4'd0, 32'h6);

        // R8: abort in RUN skips flags of that descriptor
        put_desc(1, 1, 40, 32'h40);
        put_desc(2, 0, 2, 0);
        wr(4'd1, 32'h20);
        s0 = n_start; k0 = n_abort;
        wr(4'd0, 32'h1);
        wait_state(2);
        wr(4'd0, 32'h41);
        wait_state(0);
        chk("R8 abort pulse", n_abort - k0, 1);
        chk("R8 chain continues", n_start - s0, 2);
        rd(4'd0, v); chk("R8 no irq from aborted", v, 32'h2);
        wr(4'd0, 32'h6);

        // R9: abort during fetch waits for all eight words
        put_desc(1, 1, 3, 0);
        wr(4'd1, 32'h20);
        s0 = n_start; r0 = n_req;
        wr(4'd0, 32'h1);
        wr(4'd0, 32'h41);
        wait_state(0);
        chk("R9 full fetch", n_req - r0, 8);
        chk("R9 no start", n_start - s0, 0);
        rd(4'd0, v); chk("R9 no flags", v, 0);
        rd(4'd1, v); chk("R9 advanced to null", v, 0);

        // R12: soft reset in RUN
        put_desc(1, 1, 40, 32'h40);
        wr(4'd1, 32'h20);
        k0 = n_abort;
        wr(4'd0, 32'h1);
        wait_state(2);
        wr(4'd0, 32'h81);
        rd(4'd0, v); chk("R12 ctrl cleared", v, 0);
        rd(4'd1, v); chk("R12 daddr cleared", v, 0);
        rd(4'd3, v); chk("R12 src cleared", v, 0);
        rd(4'd8, v); chk("R12 idle", v, 0);
        chk("R12 engine abort", n_abort - k0, 1);

        summary();
    end

endmodule